// File: doc/BRIEF.md
# Graphics Aperture Page Translator

This block maps byte offsets inside a linear graphics aperture onto physical memory addresses. It uses a flat, single-level table held on chip, with one 32-bit entry for each 4 KB page. With the default parameters the table has 2048 entries, which covers an 8 MB aperture. Entry n serves aperture offsets n*4096 through n*4096+4095. Each entry carries a page-aligned frame address in bits [31:12] and a valid flag in bit 0.

Software reaches the block through a simple register port with a registered read return. A control word at byte offset 0x2020 holds a table base field and the global translation enable. The table itself appears as a window of consecutive 32-bit words starting at byte offset 0x10000, in ascending page order.

A lookup port takes an aperture offset. One cycle later it returns either the translated physical address or a fault. The translation mode is a two-state machine:
- XL_DISABLED is the reset state.
- A write to the control word with bit 0 set takes the path GO_ENABLE into XL_ENABLED.
- A control write with bit 0 clear takes GO_DISABLE back to XL_DISABLED.
- Every other cycle takes HOLD and keeps the current state.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, lk_valid, lk_fault, lk_paddr and reg_rvalid are 0, translation is in XL_DISABLED, and the control word reads 0.
- R2: The control word sits at byte offset 0x2020. A write stores bits [31:12] as the base field and bit 0 as the enable. A read returns the base field in [31:12], the enable in bit 0 and zeros in [11:1].
- R3: Table entry n is written and read at byte offset 0x10000 + 4*n. A read returns the last written 32-bit value.
- R4: For a good lookup, lk_paddr equals entry bits [31:12] joined with lk_off bits [11:0], where the entry index is lk_off / 4096.
- R5: lk_valid is high exactly in the cycle after a cycle with lk_req high.
- R6: A lookup whose entry has bit 0 equal to 0 returns lk_fault=1 and lk_paddr=0.
- R7: A lookup while translation is in XL_DISABLED returns lk_fault=1 and lk_paddr=0, even when the entry is valid.
- R8: A lookup with lk_off at or beyond N_ENTRIES*4096 returns lk_fault=1 and lk_paddr=0.
- R9: A table or control write takes effect for lookups issued in the next cycle or later. A lookup issued in the same cycle as the write sees the old contents.
- R10: Writes to a table word index at or beyond N_ENTRIES, to a table address that is not word-aligned, or to any unmapped offset change nothing. Reads at those offsets return 0.
- R11: reg_rdata is valid, with reg_rvalid high, exactly in the cycle after a cycle with reg_rd high.
- R12: The mode machine moves from XL_DISABLED to XL_ENABLED on a control write with bit 0 = 1, and moves back on a control write with bit 0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| lk_req | input | 1 | Lookup request |
| lk_off | input | LK_AW | Aperture byte offset to translate |
| lk_valid | output | 1 | Lookup result valid |
| lk_fault | output | 1 | Lookup faulted |
| lk_paddr | output | DW | Translated physical address, 0 on fault |

## Verification
The bench builds the block with N_ENTRIES = 16, which gives a 64 KB aperture. This lets it fill and read back every table entry and probe the last byte of the last page. It also puts the first out-of-range offset and the first out-of-window table index within reach of short directed tests. A design that truncated the index instead of rejecting it would then visibly corrupt entry 0. The other parameters stay at their defaults, so page size and field positions match the full-size block.

// File: rtl/apx_pkg.sv
package apx_pkg;

    // Translation mode machine
    typedef enum logic [0:0] {
        XL_DISABLED = 1'b0,
        XL_ENABLED  = 1'b1
    } xl_state_e;

    // Register port decode result
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_CTRL  = 2'd1,
        RSEL_TABLE = 2'd2
    } rsel_e;

endpackage

// File: rtl/apx_table.sv
module apx_table #(
    parameter int N_ENTRIES  = 2048,
    parameter int DW         = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int IDX_W     = $clog2(N_ENTRIES),
    localparam int FRAME_W   = DW - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic [DW-1:0]      wdata,
    input  logic [IDX_W-1:0]   ridx_a,
    output logic [DW-1:0]      rdata_a,
    input  logic [IDX_W-1:0]   ridx_b,
    output logic [FRAME_W-1:0] rframe_b,
    output logic               rvld_b
);

    // Upper entry bits: plain storage, no reset
    logic [DW-1:1]        mem_q [N_ENTRIES];
    // Valid flags: reset so that unwritten entries fault
    logic [N_ENTRIES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata[DW-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[widx] <= wdata[0];
        end
    end

    always_comb begin
        rdata_a  = {mem_q[ridx_a], vld_q[ridx_a]};
        rframe_b = mem_q[ridx_b][DW-1:PAGE_SHIFT];
        rvld_b   = vld_q[ridx_b];
    end

    // A written valid flag is visible on the next cycle
    assert_write_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> vld_q[$past(widx)] == $past(wdata[0]));

endmodule

// File: rtl/apx_regif.sv
module apx_regif
    import apx_pkg::*;
#(
    parameter int N_ENTRIES          = 2048,
    parameter int DW                 = 32,
    parameter int PAGE_SHIFT         = 12,
    parameter int REG_AW             = 20,
    parameter logic [19:0] CTRL_OFS  = 20'h02020,
    parameter logic [19:0] WIN_OFS   = 20'h10000,
    localparam int IDX_W             = $clog2(N_ENTRIES),
    localparam int BASE_W            = DW - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_rvalid,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [DW-1:0]     tbl_wdata,
    input  logic [DW-1:0]     tbl_rdata,
    output logic              xl_en
);

    localparam logic [REG_AW-1:0] CTRL_A  = REG_AW'(CTRL_OFS);
    localparam logic [REG_AW-1:0] WIN_A   = REG_AW'(WIN_OFS);
    localparam logic [REG_AW-3:0] N_WORDS = (REG_AW-2)'(N_ENTRIES);

    xl_state_e            state_q, state_d;
    rsel_e                rsel;
    logic [REG_AW-1:0]    win_rel;
    logic [BASE_W-1:0]    base_q;
    logic [DW-1:0]        rdata_q;
    logic                 rvalid_q;
    logic                 ctrl_wr;

    // ---------------- address decode ----------------
    always_comb begin
        win_rel = reg_addr - WIN_A;
        rsel    = RSEL_NONE;
        if (reg_addr == CTRL_A) begin
            rsel = RSEL_CTRL;
        end else if ((reg_addr >= WIN_A) && (win_rel[1:0] == 2'b00)
                     && (win_rel[REG_AW-1:2] < N_WORDS)) begin
            rsel = RSEL_TABLE;
        end
    end

    assign ctrl_wr   = reg_wr && (rsel == RSEL_CTRL);
    assign tbl_we    = reg_wr && (rsel == RSEL_TABLE);
    assign tbl_idx   = win_rel[IDX_W+1:2];
    assign tbl_wdata = reg_wdata;

    // ---------------- mode machine: state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XL_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- mode machine: transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XL_DISABLED: if (ctrl_wr && reg_wdata[0])  state_d = XL_ENABLED;   // GO_ENABLE
            XL_ENABLED:  if (ctrl_wr && !reg_wdata[0]) state_d = XL_DISABLED;  // GO_DISABLE
            default:     state_d = XL_DISABLED;
        endcase
    end

    // ---------------- mode machine: outputs ----------------
    always_comb begin
        unique case (state_q)
            XL_ENABLED:  xl_en = 1'b1;
            XL_DISABLED: xl_en = 1'b0;
            default:     xl_en = 1'b0;
        endcase
    end

    // ---------------- base field ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (ctrl_wr) begin
            base_q <= reg_wdata[DW-1:PAGE_SHIFT];
        end
    end

    // ---------------- registered read return ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd;
            if (reg_rd) begin
                unique case (rsel)
                    RSEL_CTRL:  rdata_q <= {base_q, {(PAGE_SHIFT-1){1'b0}}, xl_en};
                    RSEL_TABLE: rdata_q <= tbl_rdata;
                    default:    rdata_q <= '0;
                endcase
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;

    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && (rsel == RSEL_NONE) |=> reg_rdata == '0);
    assert_go_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && reg_wdata[0] |=> xl_en);
    assert_go_disable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !reg_wdata[0] |=> !xl_en);
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(xl_en));

endmodule

// File: rtl/apx_lookup.sv
module apx_lookup #(
    parameter int N_ENTRIES  = 2048,
    parameter int DW         = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int LK_AW      = 32,
    localparam int IDX_W     = $clog2(N_ENTRIES),
    localparam int FRAME_W   = DW - PAGE_SHIFT,
    localparam logic [LK_AW:0] APER_BYTES = (LK_AW+1)'(N_ENTRIES) << PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [LK_AW-1:0]   lk_off,
    input  logic               xl_en,
    output logic [IDX_W-1:0]   ent_idx,
    input  logic [FRAME_W-1:0] ent_frame,
    input  logic               ent_vld,
    output logic               lk_valid,
    output logic               lk_fault,
    output logic [DW-1:0]      lk_paddr
);

    logic          in_range;
    logic          good;
    logic [DW-1:0] paddr_n;
    logic          valid_q, fault_q;
    logic [DW-1:0] paddr_q;

    always_comb begin
        in_range = {1'b0, lk_off} < APER_BYTES;
        ent_idx  = lk_off[PAGE_SHIFT +: IDX_W];
        good     = xl_en && in_range && ent_vld;
        paddr_n  = {ent_frame, lk_off[PAGE_SHIFT-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            fault_q <= 1'b0;
            paddr_q <= '0;
        end else begin
            valid_q <= lk_req;
            fault_q <= lk_req && !good;
            paddr_q <= (lk_req && good) ? paddr_n : '0;
        end
    end

    assign lk_valid = valid_q;
    assign lk_fault = fault_q;
    assign lk_paddr = paddr_q;

    assert_req_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid && !lk_fault);
    assert_invalid_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !ent_vld |=> lk_fault && (lk_paddr == '0));
    assert_disabled_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !xl_en |=> lk_fault && (lk_paddr == '0));
    assert_range_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && ({1'b0, lk_off} >= APER_BYTES) |=> lk_fault);
    assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_fault |-> lk_paddr[PAGE_SHIFT-1:0] == $past(lk_off[PAGE_SHIFT-1:0]));

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
    import apx_pkg::*;
#(
    parameter int N_ENTRIES          = 2048,
    parameter int DW                 = 32,
    parameter int PAGE_SHIFT         = 12,
    parameter int REG_AW             = 20,
    parameter int LK_AW              = 32,
    parameter logic [19:0] CTRL_OFS  = 20'h02020,
    parameter logic [19:0] WIN_OFS   = 20'h10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_rvalid,
    input  logic              lk_req,
    input  logic [LK_AW-1:0]  lk_off,
    output logic              lk_valid,
    output logic              lk_fault,
    output logic [DW-1:0]     lk_paddr
);

    localparam int IDX_W   = $clog2(N_ENTRIES);
    localparam int FRAME_W = DW - PAGE_SHIFT;

    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_idx;
    logic [DW-1:0]      tbl_wdata;
    logic [DW-1:0]      tbl_rdata;
    logic               xl_en;
    logic [IDX_W-1:0]   lk_idx;
    logic [FRAME_W-1:0] lk_frame;
    logic               lk_ent_vld;

    apx_regif #(
        .N_ENTRIES (N_ENTRIES),
        .DW        (DW),
        .PAGE_SHIFT(PAGE_SHIFT),
        .REG_AW    (REG_AW),
        .CTRL_OFS  (CTRL_OFS),
        .WIN_OFS   (WIN_OFS)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_wdata (tbl_wdata),
        .tbl_rdata (tbl_rdata),
        .xl_en     (xl_en)
    );

    apx_table #(
        .N_ENTRIES (N_ENTRIES),
        .DW        (DW),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .widx    (tbl_idx),
        .wdata   (tbl_wdata),
        .ridx_a  (tbl_idx),
        .rdata_a (tbl_rdata),
        .ridx_b  (lk_idx),
        .rframe_b(lk_frame),
        .rvld_b  (lk_ent_vld)
    );

    apx_lookup #(
        .N_ENTRIES (N_ENTRIES),
        .DW        (DW),
        .PAGE_SHIFT(PAGE_SHIFT),
        .LK_AW     (LK_AW)
    ) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_off   (lk_off),
        .xl_en    (xl_en),
        .ent_idx  (lk_idx),
        .ent_frame(lk_frame),
        .ent_vld  (lk_ent_vld),
        .lk_valid (lk_valid),
        .lk_fault (lk_fault),
        .lk_paddr (lk_paddr)
    );

endmodule

// File: tb/aperture_xlate_bench.sv
`timescale 1ns/1ps
module aperture_xlate_bench;

    localparam int N  = 16;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rvalid;
    logic          lk_req = 1'b0;
    logic [31:0]   lk_off = '0;
    logic          lk_valid, lk_fault;
    logic [31:0]   lk_paddr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] model [N];

    always #2.5 clk = ~clk;   // 200 MHz

    aperture_xlate #(.N_ENTRIES(N), .REG_AW(AW)) u_aperture_xlate (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .lk_req(lk_req), .lk_off(lk_off),
        .lk_valid(lk_valid), .lk_fault(lk_fault), .lk_paddr(lk_paddr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata; v = reg_rvalid;
    endtask

    task automatic lookup(input logic [31:0] off, output logic v, output logic f,
                          output logic [31:0] pa);
        @(negedge clk);
        lk_req = 1'b1; lk_off = off;
        @(negedge clk);
        lk_req = 1'b0;
        v = lk_valid; f = lk_fault; pa = lk_paddr;
    endtask

    function automatic logic [31:0] xlate(input logic [31:0] off);
        return {model[off[15:12]][31:12], off[11:0]};
    endfunction

    task automatic t_reset;
        logic [31:0] d; logic v;
        check("R1 lk_valid", {31'b0, lk_valid}, 32'd0);
        check("R1 lk_fault", {31'b0, lk_fault}, 32'd0);
        check("R1 lk_paddr", lk_paddr, 32'd0);
        check("R1 reg_rvalid", {31'b0, reg_rvalid}, 32'd0);
        reg_read(20'h02020, d, v);
        check("R1 ctrl reads zero", d, 32'd0);
        check("R11 rvalid after read", {31'b0, v}, 32'd1);
        @(negedge clk);
        check("R11 rvalid drops", {31'b0, reg_rvalid}, 32'd0);
    endtask

    task automatic t_ctrl;
        logic [31:0] d; logic v;
        reg_write(20'h02020, 32'hABCDE7FF);
        reg_read(20'h02020, d, v);
        check("R2 ctrl readback enabled", d, 32'hABCDE001);
        reg_write(20'h02020, 32'h12345FFE);
        reg_read(20'h02020, d, v);
        check("R2 R12 ctrl readback disabled", d, 32'h12345000);
    endtask

    task automatic t_fill;
        logic [31:0] d; logic v;
        for (int n = 0; n < N; n++) begin
            model[n] = ((32'h80000 + 32'(n) * 3) << 12) | 32'h00000A51 | ((n == 5) ? 32'h0 : 32'h1);
            if (n == 5) model[n] = model[n] & 32'hFFFFFFFE;
            reg_write(20'h10000 + 20'(4 * n), model[n]);
        end
        reg_read(20'h1000C, d, v);
        check("R3 entry 3 readback", d, model[3]);
        reg_read(20'h10014, d, v);
        check("R3 entry 5 readback", d, model[5]);
        reg_read(20'h1003C, d, v);
        check("R3 entry 15 readback", d, model[15]);
    endtask

    task automatic t_translate;
        logic v, f; logic [31:0] pa;
        logic [31:0] offs [5] = '{32'h0, 32'h1234, 32'h3FFF, 32'h7ABC, 32'hFFFF};
        reg_write(20'h02020, 32'h00000001);
        foreach (offs[i]) begin
            lookup(offs[i], v, f, pa);
            check("R5 lk_valid", {31'b0, v}, 32'd1);
            check("R4 fault clear", {31'b0, f}, 32'd0);
            check("R4 paddr", pa, xlate(offs[i]));
        end
        @(negedge clk);
        check("R5 no request no valid", {31'b0, lk_valid}, 32'd0);
    endtask

    task automatic t_invalid;
        logic v, f; logic [31:0] pa;
        lookup(32'h5010, v, f, pa);
        check("R6 invalid fault", {31'b0, f}, 32'd1);
        check("R6 invalid paddr", pa, 32'd0);
    endtask

    task automatic t_disabled;
        logic v, f; logic [31:0] pa;
        reg_write(20'h02020, 32'h0);
        lookup(32'h0100, v, f, pa);
        check("R7 disabled fault", {31'b0, f}, 32'd1);
        check("R7 disabled paddr", pa, 32'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 20'h02020; reg_wdata = 32'h1;
        lk_req = 1'b1; lk_off = 32'h0100;
        @(negedge clk);
        reg_wr = 1'b0; lk_req = 1'b0;
        check("R9 R12 same-cycle enable sees disabled", {31'b0, lk_fault}, 32'd1);
        lookup(32'h0100, v, f, pa);
        check("R12 enabled next cycle", pa, xlate(32'h0100));
    endtask

    task automatic t_range;
        logic v, f; logic [31:0] pa;
        lookup(32'h00010000, v, f, pa);
        check("R8 first byte past aperture", {31'b0, f}, 32'd1);
        check("R8 paddr zero", pa, 32'd0);
        lookup(32'hFFFFFFFF, v, f, pa);
        check("R8 far offset", {31'b0, f}, 32'd1);
    endtask

    task automatic t_update;
        logic [31:0] old;
        logic v, f; logic [31:0] pa;
        old = xlate(32'h2345);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 20'h10008; reg_wdata = 32'hCAFE0001;
        lk_req = 1'b1; lk_off = 32'h2345;
        @(negedge clk);
        reg_wr = 1'b0; lk_req = 1'b0;
        check("R9 same cycle sees old", lk_paddr, old);
        model[2] = 32'hCAFE0001;
        lookup(32'h2345, v, f, pa);
        check("R9 next cycle sees new", pa, 32'hCAFE0345);
    endtask

    task automatic t_window;
        logic [31:0] d; logic v;
        logic vv, f; logic [31:0] pa;
        reg_write(20'h10040, 32'hDEAD0001);
        reg_write(20'h10002, 32'hBEEF0001);
        reg_write(20'h00004, 32'h5555AAAB);
        reg_read(20'h10040, d, v);
        check("R10 out-of-window read", d, 32'd0);
        reg_read(20'h00004, d, v);
        check("R10 unmapped read", d, 32'd0);
        reg_read(20'h10000, d, v);
        check("R10 entry 0 untouched", d, model[0]);
        reg_read(20'h02020, d, v);
        check("R10 ctrl untouched", d, 32'h00000001);
        lookup(32'h0042, vv, f, pa);
        check("R10 page 0 translation intact", pa, xlate(32'h0042));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            rst_n = 1'b1;
        end
        @(negedge clk);
        t_reset;
        t_ctrl;
        t_fill;
        t_translate;
        t_invalid;
        t_disabled;
        t_range;
        t_update;
        t_window;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule